// File: doc/BRIEF.md
# Interleaved I/Q Word Splitter with Phase Sync

This block takes one parallel input port that carries I and Q samples on alternate words. It sorts them onto separate I and Q outputs that update once per completed pair. Each word is qualified by `in_valid`; a cycle with `in_valid` low is not a data-clock edge, and the block ignores it completely.

The I/Q phase comes from a sync input that is sampled only on accepted words. When the effective sync level is low on one accepted word and high on the next, that next word is taken as an I word. A configuration pin inverts the sync level before any other use. Once the phase is set, it runs on by itself. The sync input may then stay high, or go high on every I word and low on every Q word.

A second configuration pin selects the pairing. With it clear, each I word is paired with the Q word that follows it. With it set, each Q word is paired with the I word that follows it, so the first I word after locking has no partner and is dropped.

Streaming rules: the input has no ready signal, because the block accepts a word on every cycle that `in_valid` is high. The output is a one-cycle strobe with no back-pressure. A consumer that cannot take a pair on the strobe cycle loses it. Both configuration pins are meant to change only while reset is asserted.

Top module: `iq_pair_splitter`

## Requirements
- R1: On an accepted word where the effective sync is high and was low on the previous accepted word, that word is an I word. The sync level counts as low after reset. `locked` is 1 from the next cycle onward.
- R2: The effective sync level is `in_sync XOR cfg_sync_inv`. With `cfg_sync_inv`=1, a low `in_sync` acts as high and a high `in_sync` acts as low.
- R3: While `locked` is 0, accepted words produce no strobe, and `out_i`/`out_q` keep their values.
- R4: After locking, accepted words alternate Q, I, Q, … starting after the locking I word. Holding the effective sync high does not disturb this alternation.
- R5: A sync that goes high on every I word and low on every Q word is accepted. If a rising sync lands on a word that the running phase calls I, the phase is unchanged. If it lands on a word that the running phase calls Q, that word is re-taken as I, and an I word waiting for its Q is dropped.
- R6: With `cfg_q_first`=0, `out_valid` is 1 in the cycle after each Q word that follows an I word. In that cycle `out_i` holds that I word and `out_q` holds that Q word.
- R7: With `cfg_q_first`=1, the first I word after locking is discarded. `out_valid` is 1 in the cycle after each I word that follows a Q word. In that cycle `out_i` holds that I word and `out_q` holds the preceding Q word.
- R8: `out_valid` is high for exactly one cycle per pair and is never high in two consecutive cycles. `out_i` and `out_q` change only in strobe cycles.
- R9: While reset is asserted and in the first cycle after it, `out_valid`=0, `locked`=0, and `out_i`=`out_q`=0.
- R10: A cycle with `in_valid`=0 neither samples the sync input nor advances the phase, whatever `in_sync` and `in_word` are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sync_inv | input | 1 | Inverts the sync input level |
| cfg_q_first | input | 1 | 0: pair I with following Q; 1: pair Q with following I |
| in_valid | input | 1 | Word present this cycle (data-clock edge) |
| in_word | input | WORD_W | Interleaved I/Q word |
| in_sync | input | 1 | Phase sync / enable level |
| out_valid | output | 1 | One-cycle strobe: new pair on the outputs |
| out_i | output | WORD_W | I word of the latest pair |
| out_q | output | WORD_W | Q word of the latest pair |
| locked | output | 1 | I/Q phase has been established |

## Verification
The hardest case to reach is a rising sync that lands on a word the running phase already calls Q. A correct source never produces this, so it only happens through a deliberate phase slip. The stimulus first locks and completes a pair with sync held high. It then sends one word with sync low, which the phase calls I. The next word goes out with sync high, which forces a re-alignment. A final word then shows that the waiting I word was dropped and the re-taken word was paired. Idle cycles with a toggling sync are placed between words to show that only accepted words move the phase.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
  typedef enum logic {
    KIND_Q = 1'b0,
    KIND_I = 1'b1
  } word_kind_e;

  typedef enum logic {
    PAIR_I_THEN_Q = 1'b0,
    PAIR_Q_THEN_I = 1'b1
  } pair_mode_e;
endpackage

// File: rtl/iqs_phase_track.sv
module iqs_phase_track
  import iqs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       invert,
  input  logic       word_en,
  input  logic       sync_raw,
  output logic       take,
  output logic       first_lock,
  output word_kind_e kind,
  output logic       is_locked
);
  logic sync_eff;
  logic sync_last_q;
  logic expect_i_q;
  logic rise;

  assign sync_eff   = sync_raw ^ invert;
  assign rise       = word_en && sync_eff && !sync_last_q;
  assign take       = word_en && (rise || is_locked);
  assign first_lock = rise && !is_locked;

  always_comb begin
    if (rise) kind = KIND_I;
    else      kind = expect_i_q ? KIND_I : KIND_Q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_last_q <= 1'b0;
      expect_i_q  <= 1'b0;
      is_locked   <= 1'b0;
    end else if (word_en) begin
      sync_last_q <= sync_eff;
      if (rise) begin
        is_locked  <= 1'b1;
        expect_i_q <= 1'b0;
      end else if (is_locked) begin
        expect_i_q <= ~expect_i_q;
      end
    end
  end
endmodule

// File: rtl/iqs_pairer.sv
module iqs_pairer
  import iqs_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  pair_mode_e        mode,
  input  logic              take,
  input  logic              first_lock,
  input  word_kind_e        kind,
  input  logic [WORD_W-1:0] word,
  output logic              pair_valid,
  output logic [WORD_W-1:0] pair_i,
  output logic [WORD_W-1:0] pair_q
);
  logic [WORD_W-1:0] held_q;
  logic              have_q;
  logic              have_now;
  word_kind_e        store_kind;
  logic              store_hit;
  logic              emit_hit;

  // The held word is an I word in I-then-Q mode and a Q word in Q-then-I mode.
  assign store_kind = (mode == PAIR_I_THEN_Q) ? KIND_I : KIND_Q;
  assign have_now   = have_q && !first_lock;
  assign store_hit  = take && (kind == store_kind);
  assign emit_hit   = take && (kind != store_kind) && have_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q     <= '0;
      have_q     <= 1'b0;
      pair_valid <= 1'b0;
      pair_i     <= '0;
      pair_q     <= '0;
    end else begin
      pair_valid <= emit_hit;
      if (store_hit) begin
        held_q <= word;
        have_q <= 1'b1;
      end else if (take) begin
        have_q <= 1'b0;
      end
      if (emit_hit) begin
        if (mode == PAIR_I_THEN_Q) begin
          pair_i <= held_q;
          pair_q <= word;
        end else begin
          pair_i <= word;
          pair_q <= held_q;
        end
      end
    end
  end
endmodule

// File: rtl/iq_pair_splitter.sv
module iq_pair_splitter
  import iqs_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_sync_inv,
  input  logic              cfg_q_first,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_sync,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_i,
  output logic [WORD_W-1:0] out_q,
  output logic              locked
);
  logic       take_w;
  logic       first_w;
  word_kind_e kind_w;
  pair_mode_e mode_w;

  assign mode_w = cfg_q_first ? PAIR_Q_THEN_I : PAIR_I_THEN_Q;

  iqs_phase_track u_phase (
    .clk        (clk),
    .rst        (rst),
    .invert     (cfg_sync_inv),
    .word_en    (in_valid),
    .sync_raw   (in_sync),
    .take       (take_w),
    .first_lock (first_w),
    .kind       (kind_w),
    .is_locked  (locked)
  );

  iqs_pairer #(.WORD_W(WORD_W)) u_pair (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_w),
    .take       (take_w),
    .first_lock (first_w),
    .kind       (kind_w),
    .word       (in_word),
    .pair_valid (out_valid),
    .pair_i     (out_i),
    .pair_q     (out_q)
  );
endmodule

// File: rtl/iq_pair_splitter_chk.sv
module iq_pair_splitter_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_sync_inv,
  input logic              in_valid,
  input logic              in_sync,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_i,
  input logic [WORD_W-1:0] out_q,
  input logic              locked
);
  AST_LOCK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_sync ^ cfg_sync_inv) |=> locked); // R1
  AST_NO_PAIR_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !locked |=> !out_valid); // R3
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R8
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_i) && $stable(out_q)); // R8
  AST_STROBE_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R10
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R4
endmodule

bind iq_pair_splitter iq_pair_splitter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_sync_inv (cfg_sync_inv),
  .in_valid     (in_valid),
  .in_sync      (in_sync),
  .out_valid    (out_valid),
  .out_i        (out_i),
  .out_q        (out_q),
  .locked       (locked)
);

// File: tb/test_iq_pair_splitter.sv
module test_iq_pair_splitter;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_sync_inv = 1'b0;
  logic         cfg_q_first = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         in_sync = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_i;
  logic [W-1:0] out_q;
  logic         locked;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  iq_pair_splitter #(.WORD_W(W)) i_iq_pair_splitter (
    .clk(clk), .rst(rst), .cfg_sync_inv(cfg_sync_inv), .cfg_q_first(cfg_q_first),
    .in_valid(in_valid), .in_word(in_word), .in_sync(in_sync),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .locked(locked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; returns at the next negedge, where the result of this word is visible.
  task automatic push(input logic [W-1:0] w, input logic s);
    in_valid = 1'b1; in_word = w; in_sync = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input logic s);
    in_valid = 1'b0; in_sync = s; in_word = 12'hBAD;
    @(negedge clk);
  endtask

  task automatic pair_is(input string req, input logic [W-1:0] ei, input logic [W-1:0] eq);
    chk({req, " strobe"}, out_valid, 1);
    chk({req, " i"}, out_i, ei);
    chk({req, " q"}, out_q, eq);
  endtask

  task automatic do_reset(input logic inv, input logic qf);
    @(negedge clk);
    rst = 1'b1; cfg_sync_inv = inv; cfg_q_first = qf; in_valid = 1'b0; in_sync = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(0, 0);
    chk("R9 valid", out_valid, 0);
    chk("R9 locked", locked, 0);
    chk("R9 out_i", out_i, 0);
    chk("R9 out_q", out_q, 0);
  endtask

  task automatic t_unlocked;
    do_reset(0, 0);
    for (int k = 0; k < 4; k++) begin
      push(W'(12'h100 + k), 1'b0);
      chk("R3 no strobe", out_valid, 0);
    end
    chk("R3 locked", locked, 0);
    chk("R3 out_i", out_i, 0);
    chk("R3 out_q", out_q, 0);
  endtask

  task automatic t_held_high;
    do_reset(0, 0);
    push(12'h011, 1'b1);
    chk("R1 locked", locked, 1);
    chk("R1 no strobe on I", out_valid, 0);
    push(12'h0A1, 1'b1);
    pair_is("R6 pair1", 12'h011, 12'h0A1);
    idle(1'b1);
    chk("R8 one cycle", out_valid, 0);
    chk("R8 hold i", out_i, 12'h011);
    chk("R8 hold q", out_q, 12'h0A1);
    push(12'h012, 1'b1);
    chk("R4 no strobe on I", out_valid, 0);
    push(12'h0A2, 1'b1);
    pair_is("R4 pair2", 12'h012, 12'h0A2);
  endtask

  task automatic t_invert;
    do_reset(1, 0);
    push(12'h301, 1'b1);
    chk("R2 high ignored", locked, 0);
    push(12'h302, 1'b0);
    chk("R2 low locks", locked, 1);
    push(12'h3A2, 1'b0);
    pair_is("R2 pair", 12'h302, 12'h3A2);
  endtask

  task automatic t_toggle;
    do_reset(0, 0);
    for (int k = 0; k < 3; k++) begin
      push(W'(12'h400 + k), 1'b1);
      chk("R5 no strobe on I", out_valid, 0);
      push(W'(12'h4A0 + k), 1'b0);
      pair_is("R5 toggle pair", W'(12'h400 + k), W'(12'h4A0 + k));
    end
  endtask

  task automatic t_realign;
    do_reset(0, 0);
    push(12'h501, 1'b1);
    push(12'h5A1, 1'b1);
    pair_is("R5 pre", 12'h501, 12'h5A1);
    push(12'h502, 1'b0);
    chk("R5 phase I", out_valid, 0);
    push(12'h503, 1'b1);
    chk("R5 forced I no strobe", out_valid, 0);
    push(12'h5A3, 1'b1);
    pair_is("R5 realigned", 12'h503, 12'h5A3);
  endtask

  task automatic t_q_first;
    do_reset(0, 1);
    push(12'h601, 1'b1);
    chk("R7 first I dropped", out_valid, 0);
    push(12'h6A1, 1'b1);
    chk("R7 no strobe on Q", out_valid, 0);
    push(12'h602, 1'b1);
    pair_is("R7 pair I2Q1", 12'h602, 12'h6A1);
    push(12'h6A2, 1'b1);
    chk("R7 no strobe on Q2", out_valid, 0);
    chk("R7 hold q", out_q, 12'h6A1);
    push(12'h603, 1'b1);
    pair_is("R7 pair I3Q2", 12'h603, 12'h6A2);
  endtask

  task automatic t_gaps;
    do_reset(0, 0);
    idle(1'b1);
    idle(1'b0);
    chk("R10 idle no lock", locked, 0);
    push(12'h701, 1'b1);
    idle(1'b0);
    idle(1'b1);
    idle(1'b0);
    push(12'h7A1, 1'b1);
    pair_is("R10 gapped pair", 12'h701, 12'h7A1);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_unlocked();
    t_held_high();
    t_invert();
    t_toggle();
    t_realign();
    t_q_first();
    t_gaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule